// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small fully associative cache of recent virtual-to-physical page translations. It sits between the address path of a core and a page table walker. Every cached translation carries a virtual page number, an address-space identifier, a physical frame number and four permission flags. A lookup presents a page number, the identifier of the running context and the access kind. When a valid entry carries the same page number and the same identifier, the frame and flags come back combinationally in that cycle. Otherwise a walk request leaves the block in that cycle, carrying the lookup's page, identifier and access kind.

The walker returns its result through the refill port, and the entry is written at the next clock edge. The identifier tag means that a context switch only changes the identifier that lookups present. Entries owned by other contexts stay resident and match again when their owner runs. Software-directed invalidation can clear every entry, every entry of one identifier, or the single entry of one page in one identifier. Checking permissions against the access kind is done by a neighbouring unit. Two saturating counters report how many lookups hit and how many missed.

Top module: `asid_xlate_cache`

## Requirements
- R1: A lookup whose page number and identifier both equal those of a valid entry raises `lk_hit` in the same cycle and drives that entry's frame on `lk_pfn` and its flags on `lk_perm`. The flag bits are: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 3 no-execute.
- R2: A lookup that finds no such entry keeps `lk_hit` low and raises `walk_req` in the same cycle. `walk_vpn`, `walk_asid` and `walk_acc` carry the lookup's page, identifier and access kind, coded 0 for load, 1 for store and 2 for instruction fetch.
- R3: A refill accepted at a clock edge makes its page and identifier hit, with the refilled frame and flags, from the next cycle on.
- R4: A match needs both fields. The same page under a different identifier misses. Entries of one identifier stay valid while lookups present another identifier.
- R5: While any entry is invalid, a refill of a new key goes into the lowest-numbered invalid entry and evicts nothing.
- R6: When all entries are valid, a refill of a new key evicts the entry at a round-robin pointer. The pointer starts at entry 0 after reset and advances by one, wrapping, on each such eviction only.
- R7: A refill whose page and identifier already sit in a valid entry overwrites that entry's frame and flags. It evicts nothing and leaves the round-robin pointer unchanged.
- R8: Asserting `inv_all` leaves every entry invalid after the next clock edge.
- R9: Asserting `inv_asid_en` invalidates, at the next edge, exactly those entries whose identifier equals `inv_asid`.
- R10: Asserting `inv_page_en` invalidates, at the next edge, only an entry whose page equals `inv_vpn` and whose identifier equals `inv_asid`. The same page under another identifier is kept.
- R11: A refill presented in a cycle in which any invalidation input is high is discarded.
- R12: Each lookup cycle adds one to `hit_count` on a hit, or to `miss_count` on a miss. Each counter holds at its all-ones value instead of wrapping.
- R13: After reset, no entry is valid, both counters read zero and the round-robin pointer is at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup present this cycle |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Identifier of the running context |
| lk_acc | input | 2 | Access kind (0 load, 1 store, 2 fetch) |
| lk_hit | output | 1 | Lookup found a matching entry |
| lk_pfn | output | PFN_W | Frame number of the matching entry |
| lk_perm | output | PERM_W | Flags of the matching entry |
| walk_req | output | 1 | Miss handed to the walker |
| walk_vpn | output | VPN_W | Page number for the walker |
| walk_asid | output | ASID_W | Identifier for the walker |
| walk_acc | output | 2 | Access kind for the walker |
| fill_valid | input | 1 | Refill present this cycle |
| fill_vpn | input | VPN_W | Refill page number |
| fill_asid | input | ASID_W | Refill identifier |
| fill_pfn | input | PFN_W | Refill frame number |
| fill_perm | input | PERM_W | Refill flags |
| inv_all | input | 1 | Invalidate every entry |
| inv_asid_en | input | 1 | Invalidate all entries of `inv_asid` |
| inv_page_en | input | 1 | Invalidate the entry of `inv_vpn` under `inv_asid` |
| inv_asid | input | ASID_W | Identifier operand for invalidation |
| inv_vpn | input | VPN_W | Page operand for invalidation |
| hit_count | output | CNT_W | Saturating count of hits |
| miss_count | output | CNT_W | Saturating count of misses |

## Verification
Lookups use keys that differ only in the page, keys that differ only in the identifier, and keys that match fully. This shows that both tag fields take part in the match. Sixteen distinct refills fill the array. A page invalidation then opens a hole, and further refills go in one at a time. Which earlier keys still hit and which now miss shows where the hole was refilled and the order of round-robin eviction. A refill of an already cached key shows whether the block overwrites in place or duplicates the key. A refill issued together with an invalidation, and a long run of hits on one key, cover the ordering rule and the counter ceiling.

// File: rtl/xlc_pkg.sv
package xlc_pkg;
  // Permission flag positions inside the PERM field
  localparam int unsigned PERM_BITS   = 4;
  localparam int unsigned PB_PRESENT  = 0;
  localparam int unsigned PB_WRITE    = 1;
  localparam int unsigned PB_USER     = 2;
  localparam int unsigned PB_NOEXEC   = 3;

  // Access kind carried with a lookup and forwarded to the walker
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;
endpackage

// File: rtl/xlc_sat_cnt.sv
module xlc_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_nxt;
  logic         at_top;

  always_comb begin
    at_top  = &cnt_q;
    cnt_nxt = cnt_q;
    if (inc && !at_top) cnt_nxt = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/xlc_tag_store.sv
module xlc_tag_store #(
  parameter int unsigned N      = 16,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned PFN_W  = 20,
  parameter int unsigned PERM_W = 4,
  parameter int unsigned IDX_W  = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  q_vpn,
  input  logic [ASID_W-1:0] q_asid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic              inv_all,
  input  logic              inv_asid_en,
  input  logic              inv_page_en,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VPN_W-1:0]  inv_vpn,
  output logic [N-1:0]      hit_vec,
  output logic [N-1:0]      fill_match_vec,
  output logic [N-1:0]      valid_vec,
  output logic [PFN_W-1:0]  rd_pfn,
  output logic [PERM_W-1:0] rd_perm
);
  logic [N-1:0]      valid_q, valid_nxt;
  logic [N-1:0]      asid_kill, page_kill;
  logic [VPN_W-1:0]  vpn_q  [N];
  logic [ASID_W-1:0] asid_q [N];
  logic [PFN_W-1:0]  pfn_q  [N];
  logic [PERM_W-1:0] perm_q [N];

  // Per-entry comparators: lookup key, refill key, invalidation keys
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g]        = valid_q[g] && (vpn_q[g] == q_vpn) && (asid_q[g] == q_asid);
    assign fill_match_vec[g] = valid_q[g] && (vpn_q[g] == wr_vpn) && (asid_q[g] == wr_asid);
    assign asid_kill[g]      = inv_asid_en && (asid_q[g] == inv_asid);
    assign page_kill[g]      = inv_page_en && (vpn_q[g] == inv_vpn) && (asid_q[g] == inv_asid);
  end

  // Next-state of the valid bits
  always_comb begin
    valid_nxt = valid_q & ~(asid_kill | page_kill);
    if (inv_all) valid_nxt = '0;
    if (wr_en)   valid_nxt[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_nxt;
  end

  // Payload storage, written only under the refill enable
  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= wr_vpn;
      asid_q[wr_idx] <= wr_asid;
      pfn_q[wr_idx]  <= wr_pfn;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  // OR-mux of the one-hot matching entry
  always_comb begin
    rd_pfn  = '0;
    rd_perm = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        rd_pfn  = rd_pfn | pfn_q[i];
        rd_perm = rd_perm | perm_q[i];
      end
    end
  end

  assign valid_vec = valid_q;
endmodule

// File: rtl/xlc_victim_pick.sv
module xlc_victim_pick #(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     match_vec,
  input  logic             commit,
  output logic [IDX_W-1:0] victim
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  logic [IDX_W-1:0] rr_q, rr_nxt;
  logic [IDX_W-1:0] match_idx, free_idx;
  logic             match_any, full, evict;

  always_comb begin
    match_any = |match_vec;
    full      = &valid_vec;
    match_idx = '0;
    free_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i])  match_idx = IDX_W'(i);
      if (!valid_vec[i]) free_idx  = IDX_W'(i);
    end
    if (match_any)  victim = match_idx;
    else if (!full) victim = free_idx;
    else            victim = rr_q;
    evict  = commit && !match_any && full;
    rr_nxt = rr_q;
    if (evict) rr_nxt = (rr_q == LAST) ? '0 : rr_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_nxt;
  end
endmodule

// File: rtl/asid_xlate_cache.sv
module asid_xlate_cache #(
  parameter int unsigned N      = 16,
  parameter int unsigned VPN_W  = 20,
  parameter int unsigned ASID_W = 8,
  parameter int unsigned PFN_W  = 20,
  parameter int unsigned PERM_W = xlc_pkg::PERM_BITS,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [1:0]        lk_acc,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  output logic              walk_req,
  output logic [VPN_W-1:0]  walk_vpn,
  output logic [ASID_W-1:0] walk_asid,
  output logic [1:0]        walk_acc,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              inv_all,
  input  logic              inv_asid_en,
  input  logic              inv_page_en,
  input  logic [ASID_W-1:0] inv_asid,
  input  logic [VPN_W-1:0]  inv_vpn,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int unsigned IDX_W = $clog2(N);

  logic [N-1:0]     hit_vec, fill_match_vec, valid_vec;
  logic [IDX_W-1:0] victim;
  logic             any_inv, fill_ok, hit_any;
  xlc_pkg::acc_e    acc_kind;

  // Invalidation wins over a refill in the same cycle
  assign any_inv  = inv_all | inv_asid_en | inv_page_en;
  assign fill_ok  = fill_valid & ~any_inv;
  assign hit_any  = |hit_vec;
  assign acc_kind = xlc_pkg::acc_e'(lk_acc);

  xlc_tag_store #(
    .N(N), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .PERM_W(PERM_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .q_vpn(lk_vpn), .q_asid(lk_asid),
    .wr_en(fill_ok), .wr_idx(victim),
    .wr_vpn(fill_vpn), .wr_asid(fill_asid), .wr_pfn(fill_pfn), .wr_perm(fill_perm),
    .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_page_en(inv_page_en),
    .inv_asid(inv_asid), .inv_vpn(inv_vpn),
    .hit_vec(hit_vec), .fill_match_vec(fill_match_vec), .valid_vec(valid_vec),
    .rd_pfn(lk_pfn), .rd_perm(lk_perm)
  );

  xlc_victim_pick #(.N(N), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n),
    .valid_vec(valid_vec), .match_vec(fill_match_vec),
    .commit(fill_ok), .victim(victim)
  );

  xlc_sat_cnt #(.W(CNT_W)) u_hits (
    .clk(clk), .rst_n(rst_n), .inc(lk_valid & hit_any), .cnt(hit_count)
  );

  xlc_sat_cnt #(.W(CNT_W)) u_misses (
    .clk(clk), .rst_n(rst_n), .inc(lk_valid & ~hit_any), .cnt(miss_count)
  );

  assign lk_hit    = lk_valid & hit_any;
  assign walk_req  = lk_valid & ~hit_any;
  assign walk_vpn  = lk_vpn;
  assign walk_asid = lk_asid;
  assign walk_acc  = acc_kind;
endmodule

// File: rtl/xlc_chk.sv
module xlc_chk #(
  parameter int unsigned N     = 16,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_hit,
  input logic             walk_req,
  input logic             fill_valid,
  input logic             inv_all,
  input logic             inv_asid_en,
  input logic             inv_page_en,
  input logic [N-1:0]     hit_vec,
  input logic [N-1:0]     valid_vec,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);
  // R4
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R2
  hit_or_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit ^ walk_req));

  // R3
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !inv_all && !inv_asid_en && !inv_page_en) |=> (valid_vec != '0));

  // R8
  flush_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_vec == '0));

  // R11
  flush_beats_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all || inv_asid_en || inv_page_en) |=>
      ($countones(valid_vec) <= $countones($past(valid_vec))));

  // R12
  hit_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_hit) |=> $stable(hit_count));

  // R12
  miss_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_req |=> $stable(miss_count));
endmodule

bind asid_xlate_cache xlc_chk #(.N(N), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit), .walk_req(walk_req),
  .fill_valid(fill_valid), .inv_all(inv_all), .inv_asid_en(inv_asid_en),
  .inv_page_en(inv_page_en), .hit_vec(hit_vec), .valid_vec(valid_vec),
  .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/tb_asid_xlate_cache.sv
module tb_asid_xlate_cache;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic        clk, rst_n;
  logic        lk_valid;
  logic [19:0] lk_vpn;
  logic [7:0]  lk_asid;
  logic [1:0]  lk_acc;
  logic        lk_hit;
  logic [19:0] lk_pfn;
  logic [3:0]  lk_perm;
  logic        walk_req;
  logic [19:0] walk_vpn;
  logic [7:0]  walk_asid;
  logic [1:0]  walk_acc;
  logic        fill_valid;
  logic [19:0] fill_vpn, fill_pfn;
  logic [7:0]  fill_asid;
  logic [3:0]  fill_perm;
  logic        inv_all, inv_asid_en, inv_page_en;
  logic [7:0]  inv_asid;
  logic [19:0] inv_vpn;
  logic [CW-1:0] hit_count, miss_count;

  asid_xlate_cache #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_acc(lk_acc), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_asid(walk_asid), .walk_acc(walk_acc),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm), .inv_all(inv_all),
    .inv_asid_en(inv_asid_en), .inv_page_en(inv_page_en), .inv_asid(inv_asid),
    .inv_vpn(inv_vpn), .hit_count(hit_count), .miss_count(miss_count)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    bit          hit;
    logic [19:0] vpn;
    logic [7:0]  asid;
    logic [1:0]  acc;
    logic [19:0] pfn;
    logic [3:0]  perm;
    int          rq;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   fails  = 0;
  int   exp_hits = 0;
  int   exp_miss = 0;
  bit   done = 1'b0;

  task automatic check_eq(input int rq, input string what, input logic [31:0] act,
                          input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Monitor: pops the expectation pushed for this cycle and compares
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check_eq(e.rq, "hit", 32'(lk_hit), 32'(e.hit));
        check_eq(e.rq, "walk_req", 32'(walk_req), 32'(!e.hit));
        if (e.hit) begin
          check_eq(e.rq, "pfn", 32'(lk_pfn), 32'(e.pfn));
          check_eq(e.rq, "perm", 32'(lk_perm), 32'(e.perm));
        end else begin
          check_eq(e.rq, "walk_vpn", 32'(walk_vpn), 32'(e.vpn));
          check_eq(e.rq, "walk_asid", 32'(walk_asid), 32'(e.asid));
          check_eq(e.rq, "walk_acc", 32'(walk_acc), 32'(e.acc));
        end
      end
    end
  end

  task automatic clear_ctl();
    lk_valid = 1'b0; fill_valid = 1'b0;
    inv_all = 1'b0; inv_asid_en = 1'b0; inv_page_en = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    clear_ctl();
  endtask

  // Driver: applies one lookup and pushes its expected result
  task automatic lookup(input logic [19:0] v, input logic [7:0] a, input logic [1:0] acc,
                        input bit eh, input logic [19:0] ep, input logic [3:0] eperm,
                        input int rq);
    exp_t e;
    @(negedge clk);
    clear_ctl();
    lk_valid = 1'b1; lk_vpn = v; lk_asid = a; lk_acc = acc;
    e.hit = eh; e.vpn = v; e.asid = a; e.acc = acc; e.pfn = ep; e.perm = eperm; e.rq = rq;
    sb_q.push_back(e);
    if (eh) begin if (exp_hits < CMAX) exp_hits++; end
    else    begin if (exp_miss < CMAX) exp_miss++; end
  endtask

  task automatic fill(input logic [19:0] v, input logic [7:0] a, input logic [19:0] p,
                      input logic [3:0] pm);
    @(negedge clk);
    clear_ctl();
    fill_valid = 1'b1; fill_vpn = v; fill_asid = a; fill_pfn = p; fill_perm = pm;
  endtask

  task automatic flush(input bit all, input bit by_asid, input bit by_page,
                       input logic [7:0] a, input logic [19:0] v);
    @(negedge clk);
    clear_ctl();
    inv_all = all; inv_asid_en = by_asid; inv_page_en = by_page;
    inv_asid = a; inv_vpn = v;
  endtask

  task automatic check_counts(input int rq);
    idle();
    #3;
    check_eq(rq, "hit_count", 32'(hit_count), 32'(exp_hits));
    check_eq(rq, "miss_count", 32'(miss_count), 32'(exp_miss));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear_ctl();
    lk_vpn = '0; lk_asid = '0; lk_acc = '0;
    fill_vpn = '0; fill_asid = '0; fill_pfn = '0; fill_perm = '0;
    inv_asid = '0; inv_vpn = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R13: counters start at zero and nothing is cached
    check_counts(13);
    lookup(20'h00000, 8'd0, 2'd0, 1'b0, '0, '0, 13);

    // R2: miss forwards page, identifier and store access kind
    lookup(20'h12345, 8'd3, 2'd1, 1'b0, '0, '0, 2);
    lookup(20'h12345, 8'd3, 2'd2, 1'b0, '0, '0, 2);

    // R3, R1: refill then hit with frame and flags
    fill(20'h12345, 8'd3, 20'h7ABCD, 4'b0111);
    lookup(20'h12345, 8'd3, 2'd0, 1'b1, 20'h7ABCD, 4'b0111, 3);
    lookup(20'h12345, 8'd3, 2'd2, 1'b1, 20'h7ABCD, 4'b0111, 1);

    // R4: same page, other identifier misses; both then coexist
    lookup(20'h12345, 8'd4, 2'd0, 1'b0, '0, '0, 4);
    fill(20'h12345, 8'd4, 20'h11111, 4'b1101);
    lookup(20'h12345, 8'd4, 2'd0, 1'b1, 20'h11111, 4'b1101, 4);
    lookup(20'h12345, 8'd3, 2'd0, 1'b1, 20'h7ABCD, 4'b0111, 4);
    lookup(20'h12346, 8'd3, 2'd0, 1'b0, '0, '0, 4);

    // R9: flush identifier 4 only
    flush(1'b0, 1'b1, 1'b0, 8'd4, '0);
    lookup(20'h12345, 8'd4, 2'd0, 1'b0, '0, '0, 9);
    lookup(20'h12345, 8'd3, 2'd0, 1'b1, 20'h7ABCD, 4'b0111, 9);

    // R8: flush everything
    flush(1'b1, 1'b0, 1'b0, '0, '0);
    lookup(20'h12345, 8'd3, 2'd0, 1'b0, '0, '0, 8);

    // R5: fill all sixteen entries in order
    for (int i = 0; i < 16; i++) fill(20'h20000 + 20'(i), 8'd7, 20'h30000 + 20'(i), 4'b0001);
    for (int i = 0; i < 16; i++)
      lookup(20'h20000 + 20'(i), 8'd7, 2'd0, 1'b1, 20'h30000 + 20'(i), 4'b0001, 5);

    // R10: page flush of key 5; same page under another identifier keeps key 6
    flush(1'b0, 1'b0, 1'b1, 8'd7, 20'h20005);
    flush(1'b0, 1'b0, 1'b1, 8'd8, 20'h20006);
    lookup(20'h20005, 8'd7, 2'd0, 1'b0, '0, '0, 10);
    lookup(20'h20006, 8'd7, 2'd0, 1'b1, 20'h30006, 4'b0001, 10);
    lookup(20'h20004, 8'd7, 2'd0, 1'b1, 20'h30004, 4'b0001, 10);

    // R5: new key fills the hole (entry 5) without eviction
    fill(20'h40000, 8'd7, 20'h50000, 4'b0011);
    for (int i = 0; i < 16; i++)
      if (i != 5) lookup(20'h20000 + 20'(i), 8'd7, 2'd0, 1'b1, 20'h30000 + 20'(i), 4'b0001, 5);

    // R6: full array evicts entry 0 then entry 1
    fill(20'h40010, 8'd7, 20'h50010, 4'b0011);
    fill(20'h40020, 8'd7, 20'h50020, 4'b0011);
    lookup(20'h20000, 8'd7, 2'd0, 1'b0, '0, '0, 6);
    lookup(20'h20001, 8'd7, 2'd0, 1'b0, '0, '0, 6);
    lookup(20'h20002, 8'd7, 2'd0, 1'b1, 20'h30002, 4'b0001, 6);
    lookup(20'h40000, 8'd7, 2'd0, 1'b1, 20'h50000, 4'b0011, 6);
    lookup(20'h40010, 8'd7, 2'd0, 1'b1, 20'h50010, 4'b0011, 6);
    lookup(20'h40020, 8'd7, 2'd0, 1'b1, 20'h50020, 4'b0011, 6);

    // R7: refill of a cached key overwrites in place, pointer stays at 2
    fill(20'h20003, 8'd7, 20'h55555, 4'b1111);
    lookup(20'h20003, 8'd7, 2'd0, 1'b1, 20'h55555, 4'b1111, 7);
    lookup(20'h20002, 8'd7, 2'd0, 1'b1, 20'h30002, 4'b0001, 7);
    fill(20'h40030, 8'd7, 20'h50030, 4'b0011);
    lookup(20'h20002, 8'd7, 2'd0, 1'b0, '0, '0, 7);
    lookup(20'h20003, 8'd7, 2'd0, 1'b1, 20'h55555, 4'b1111, 7);

    // R11: refill together with an invalidation is dropped
    @(negedge clk);
    clear_ctl();
    fill_valid = 1'b1; fill_vpn = 20'h40040; fill_asid = 8'd7;
    fill_pfn = 20'h50040; fill_perm = 4'b0011;
    inv_page_en = 1'b1; inv_asid = 8'd9; inv_vpn = 20'h00001;
    lookup(20'h40040, 8'd7, 2'd0, 1'b0, '0, '0, 11);
    lookup(20'h20004, 8'd7, 2'd0, 1'b1, 20'h30004, 4'b0001, 11);

    // R12: counts so far, then drive the hit counter to its ceiling
    check_counts(12);
    for (int i = 0; i < 270; i++)
      lookup(20'h20003, 8'd7, 2'd0, 1'b1, 20'h55555, 4'b1111, 12);
    lookup(20'h77777, 8'd1, 2'd0, 1'b0, '0, '0, 12);
    check_counts(12);

    idle();
    idle();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule